// File: doc/BRIEF.md
# Transmitter Equalization Coefficient Acceptance Unit

This unit screens a transmitter equalization request from a link partner. The request has three coefficients: the pre-cursor (which sets pre-shoot), the main cursor (which sets boost) and the post-cursor (which sets de-emphasis). The unit compares the request with two local limits: the full-swing value and the low-frequency value. A request that meets every coefficient rule becomes the active transmitter setting. The same setting is presented back so that it can be carried in the outgoing training sets. A request that breaks any rule is refused, and the previous setting stays in force.

Requests arrive over a valid/ready handshake. The verdict and the updated setting appear together on the cycle after the handshake completes. The control is a two-state machine. ST_IDLE means no verdict is being presented. ST_RESULT means a verdict is on the outputs for exactly one cycle. The transitions are:
- T_ACCEPT_REQ: ST_IDLE to ST_RESULT, on a handshake.
- T_CHAIN: ST_RESULT to ST_RESULT, on a handshake in the verdict cycle.
- T_DRAIN: ST_RESULT to ST_IDLE, when there is no handshake.
- T_WAIT: ST_IDLE to ST_IDLE, when there is no handshake.

Top module: `txcoef_legal_chk`

## Requirements
- R1: While `rst_n` is low, the unit loads the default setting: `act_pre` = 0, `act_post` = 0 and `act_main` = `fs`. The outputs `res_valid`, `res_accept` and `res_reject` are 0.
- R2: `req_ready` is 1 in every cycle after reset, so requests can be accepted on consecutive cycles.
- R3: Each completed handshake (`req_valid` and `req_ready` both high at a rising edge) gives exactly one cycle of `res_valid` after that edge. In that cycle, exactly one of `res_accept` and `res_reject` is 1.
- R4: Pre-cursor rule. The magnitude of `req_pre` must not exceed floor(`fs`/4), which is `fs` shifted right by two.
- R5: Sum rule. |`req_pre`| + `req_main` + |`req_post`| must equal `fs` exactly.
- R6: Eye rule. `req_main` − |`req_pre`| − |`req_post`| must be at least `lf`. Equality passes.
- R7: A request that satisfies R4, R5 and R6 gives `res_accept` = 1. In the same cycle, `act_pre`, `act_main` and `act_post` show the requested values.
- R8: A request that fails any of R4, R5 or R6 gives `res_reject` = 1 for one cycle. `act_pre`, `act_main` and `act_post` keep the last legal setting.
- R9: `req_pre` and `req_post` are 6-bit two's complement values. −32 has a magnitude of 32. Positive values count by their own value. `req_main`, `fs` and `lf` are unsigned 6-bit values. Sums are formed at 8 bits, so they do not overflow.
- R10: When there is no handshake, `res_valid` is 0 in the next cycle and the active setting does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fs | input | 6 | Full-swing limit |
| lf | input | 6 | Low-frequency limit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_pre | input | 6 | Requested pre-cursor, signed |
| req_main | input | 6 | Requested main cursor, unsigned |
| req_post | input | 6 | Requested post-cursor, signed |
| res_valid | output | 1 | Verdict present this cycle |
| res_accept | output | 1 | Request applied |
| res_reject | output | 1 | Request refused |
| act_pre | output | 6 | Active pre-cursor, echoed to training sets |
| act_main | output | 6 | Active main cursor, echoed to training sets |
| act_post | output | 6 | Active post-cursor, echoed to training sets |

## Verification
Every verdict comes from state that was set one cycle earlier. A bad rule evaluation therefore shows up in the very next cycle, as the wrong one of `res_accept` or `res_reject`. It also shows up as a change, or a missing change, in the active coefficients at that same time. If the state machine gets stuck in ST_RESULT, `res_valid` rises with no handshake in the previous cycle. If it drops a transition, `res_valid` is missing one cycle after a handshake. Either fault is visible within one cycle. A corrupted active register stays visible on the echo outputs until the next legal request overwrites it.

// File: rtl/txcoef_pkg.sv
package txcoef_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } chk_state_e;

    typedef struct packed {
        logic pre_ok;
        logic sum_ok;
        logic eye_ok;
    } rule_flags_t;
endpackage

// File: rtl/txcoef_rules.sv
module txcoef_rules #(
    parameter int CW = 6
) (
    input  logic signed [CW-1:0] pre,
    input  logic        [CW-1:0] main_c,
    input  logic signed [CW-1:0] post,
    input  logic        [CW-1:0] fs,
    input  logic        [CW-1:0] lf,
    output txcoef_pkg::rule_flags_t flags
);
    localparam int SW = CW + 2;

    logic [SW-1:0] mag_pre, mag_post, main_w, fs_w, lf_w, quarter_fs;
    logic [SW-1:0] side_sum, total, eye_need;

    // Two's complement magnitude, widened so that the most negative code fits (R9)
    always_comb begin
        mag_pre  = pre[CW-1]  ? (SW'(0) - SW'(pre))  : SW'(pre);
        mag_post = post[CW-1] ? (SW'(0) - SW'(post)) : SW'(post);
        main_w     = SW'(main_c);
        fs_w       = SW'(fs);
        lf_w       = SW'(lf);
        quarter_fs = fs_w >> 2;
        side_sum   = mag_pre + mag_post;
        total      = side_sum + main_w;
        eye_need   = side_sum + lf_w;
        flags.pre_ok = (mag_pre <= quarter_fs);   // R4
        flags.sum_ok = (total == fs_w);           // R5
        flags.eye_ok = (main_w >= eye_need);      // R6
    end
endmodule

// File: rtl/txcoef_fsm.sv
module txcoef_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic ready,
    output logic verdict_cycle
);
    import txcoef_pkg::*;

    chk_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = fire ? ST_RESULT : ST_IDLE;   // T_ACCEPT_REQ / T_WAIT
            ST_RESULT: state_nx = fire ? ST_RESULT : ST_IDLE;   // T_CHAIN / T_DRAIN
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        ready         = 1'b0;
        verdict_cycle = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ready         = rst_n;
                verdict_cycle = 1'b0;
            end
            ST_RESULT: begin
                ready         = rst_n;
                verdict_cycle = 1'b1;
            end
            default: begin
                ready         = 1'b0;
                verdict_cycle = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/txcoef_legal_chk.sv
module txcoef_legal_chk #(
    parameter int CW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic        [CW-1:0] fs,
    input  logic        [CW-1:0] lf,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic signed [CW-1:0] req_pre,
    input  logic        [CW-1:0] req_main,
    input  logic signed [CW-1:0] req_post,
    output logic                 res_valid,
    output logic                 res_accept,
    output logic                 res_reject,
    output logic signed [CW-1:0] act_pre,
    output logic        [CW-1:0] act_main,
    output logic signed [CW-1:0] act_post
);
    import txcoef_pkg::*;

    rule_flags_t flags;
    logic        fire, legal;

    txcoef_rules #(.CW(CW)) u_rules (
        .pre    (req_pre),
        .main_c (req_main),
        .post   (req_post),
        .fs     (fs),
        .lf     (lf),
        .flags  (flags)
    );

    txcoef_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .fire          (fire),
        .ready         (req_ready),
        .verdict_cycle (res_valid)
    );

    assign fire  = req_valid && req_ready;
    assign legal = flags.pre_ok && flags.sum_ok && flags.eye_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pre    <= '0;
            act_main   <= fs;
            act_post   <= '0;
            res_accept <= 1'b0;
            res_reject <= 1'b0;
        end else begin
            res_accept <= fire && legal;
            res_reject <= fire && !legal;
            if (fire && legal) begin
                act_pre  <= req_pre;
                act_main <= req_main;
                act_post <= req_post;
            end
        end
    end
endmodule

module txcoef_legal_chk_sva #(
    parameter int CW = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic signed [CW-1:0] req_pre,
    input logic        [CW-1:0] req_main,
    input logic signed [CW-1:0] req_post,
    input logic                 res_valid,
    input logic                 res_accept,
    input logic                 res_reject,
    input logic signed [CW-1:0] act_pre,
    input logic        [CW-1:0] act_main,
    input logic signed [CW-1:0] act_post
);
    AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready); // R2
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> res_valid); // R3
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_accept, res_reject}) == 1); // R3
    AST_VERDICT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_accept || res_reject)); // R3
    AST_APPLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept |-> (act_pre == $past(req_pre) && act_main == $past(req_main)
                        && act_post == $past(req_post))); // R7
    AST_HOLD_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        res_reject |-> ($stable(act_pre) && $stable(act_main) && $stable(act_post))); // R8
    AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> (!res_valid && $stable(act_pre)
                                       && $stable(act_main) && $stable(act_post))); // R10
endmodule

bind txcoef_legal_chk txcoef_legal_chk_sva #(.CW(CW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_pre    (req_pre),
    .req_main   (req_main),
    .req_post   (req_post),
    .res_valid  (res_valid),
    .res_accept (res_accept),
    .res_reject (res_reject),
    .act_pre    (act_pre),
    .act_main   (act_main),
    .act_post   (act_post)
);

// File: tb/tb_txcoef_legal_chk.sv
module tb_txcoef_legal_chk;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic        [5:0] fs = 6'd24, lf = 6'd8;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic signed [5:0] req_pre = '0, req_post = '0;
    logic        [5:0] req_main = '0;
    logic              res_valid, res_accept, res_reject;
    logic signed [5:0] act_pre, act_post;
    logic        [5:0] act_main;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Expected active setting, kept by the bench
    int exp_pre = 0, exp_main = 24, exp_post = 0;

    always #5 clk = ~clk;

    txcoef_legal_chk dut (
        .clk(clk), .rst_n(rst_n), .fs(fs), .lf(lf),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_pre(req_pre), .req_main(req_main), .req_post(req_post),
        .res_valid(res_valid), .res_accept(res_accept), .res_reject(res_reject),
        .act_pre(act_pre), .act_main(act_main), .act_post(act_post)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mag(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Reference rules, taken from R4..R6 with plain integers
    function automatic bit is_legal(input int p, input int m, input int q, input int f, input int l);
        bit a, b, c;
        a = mag(p) <= (f / 4);
        b = (mag(p) + m + mag(q)) == f;
        c = (m - mag(p) - mag(q)) >= l;
        return a && b && c;
    endfunction

    task automatic check_setting(input string tag);
        check({tag, " act_pre"},  int'(act_pre),  exp_pre);
        check({tag, " act_main"}, int'(act_main), exp_main);
        check({tag, " act_post"}, int'(act_post), exp_post);
    endtask

    task automatic do_reset(input int f, input int l);
        @(negedge clk);
        rst_n = 1'b0; fs = 6'(f); lf = 6'(l); req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        exp_pre = 0; exp_main = f; exp_post = 0;
        check_setting("R1 reset");
        check("R1 res_valid", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 ready", int'(req_ready), 1);
        check("R10 idle res_valid", int'(res_valid), 0);
        check_setting("R10 idle");
    endtask

    // One request, then verify the verdict on the following cycle
    task automatic send_one(input string tag, input int p, input int m, input int q);
        bit lg;
        lg = is_legal(p, m, q, int'(fs), int'(lf));
        @(negedge clk);
        req_valid = 1'b1; req_pre = 6'(p); req_main = 6'(m); req_post = 6'(q);
        @(negedge clk);
        req_valid = 1'b0;
        if (lg) begin exp_pre = p; exp_main = m; exp_post = q; end
        check({tag, " R3 res_valid"}, int'(res_valid), 1);
        check({tag, lg ? " R7 accept" : " R8 accept"}, int'(res_accept), int'(lg));
        check({tag, lg ? " R7 reject" : " R8 reject"}, int'(res_reject), int'(!lg));
        check_setting({tag, lg ? " R7" : " R8"});
        @(negedge clk);
        check({tag, " R10 drain"}, int'(res_valid), 0);
        check_setting({tag, " R10 hold"});
    endtask

    task automatic back_to_back();
        @(negedge clk);
        req_valid = 1'b1; req_pre = -6'sd1; req_main = 6'd20; req_post = -6'sd3;
        @(negedge clk);
        check("R2 ready b2b", int'(req_ready), 1);
        check("R3 b2b first valid", int'(res_valid), 1);
        check("R7 b2b first accept", int'(res_accept), 1);
        check("R7 b2b first main", int'(act_main), 20);
        req_pre = 6'sd0; req_main = 6'd30; req_post = 6'sd0;   // sum wrong
        @(negedge clk);
        req_valid = 1'b0;
        check("R3 b2b second valid", int'(res_valid), 1);
        check("R8 b2b second reject", int'(res_reject), 1);
        exp_pre = -1; exp_main = 20; exp_post = -3;
        check_setting("R8 b2b hold");
        @(negedge clk);
        check("R10 b2b drain", int'(res_valid), 0);
    endtask

    initial begin
        do_reset(24, 8);
        send_one("legal basic",      -2, 18, -4);
        send_one("R4 pre over",      -7, 17,  0);
        send_one("R5 sum short",      0, 20, -3);
        send_one("R6 eye low",       -6, 12, -6);
        send_one("R6 eye equal",     -4, 16, -4);
        send_one("R9 positive post",  0, 20,  4);
        send_one("R4 pre at bound",  -6, 18,  0);
        send_one("R5 sum long",      -2, 20, -4);
        back_to_back();
        do_reset(63, 0);
        send_one("R9 most negative", -32, 31, 0);
        send_one("R9 legal wide",    -15, 40, -8);
        send_one("R4 positive pre",   16, 47, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end
endmodule